// File: doc/BRIEF.md
# Hybrid Dynamic/Static Branch Direction and Target Predictor

This block sits beside a fetch stage and answers, in the same cycle, two questions about the current fetch address: will the branch there be taken, and where does it go. It holds a direct-mapped cache of 128 entries, indexed by the fetch address. Each entry stores an address tag, a branch target and a 2-bit saturating history counter.

When an entry matches, the prediction comes from the upper bit of its counter, and the target comes from the entry. When no entry matches and the fetched instruction is a decoded branch, the block uses a fixed rule instead. A backward branch (negative offset) is predicted taken and a forward branch is predicted not taken, which suits loops. The static target is the fetch address plus the offset.

Resolved outcomes from the execute stage arrive on an update port. An update either trains an existing entry or, for a taken branch, allocates a new entry. A synchronous flush drops every entry at once.

Top module: `bpred_top`

## Requirements
- R1: After reset every entry is invalid, so any lookup reports `pred_hit` = 0.
- R2: The entry index is PC[8:2] and the tag is PC[31:9]. A lookup hits only if the indexed entry is valid and its tag equals PC[31:9]. An address that shares the index but has another tag misses.
- R3: On a hit, `pred_taken` is bit 1 of the entry's counter and `pred_target` is the stored target.
- R4: On a miss with `lk_is_branch` = 1, `pred_taken` equals bit 31 of `lk_offset`, which is its sign. `pred_target` is `lk_pc + lk_offset`.
- R5: On a miss with `lk_is_branch` = 0, `pred_taken` is 0 and `pred_target` is `lk_pc + lk_offset`.
- R6: A taken update that misses allocates the indexed entry. It writes the tag and target and sets the counter to 10 (weakly taken), so the next lookup hits and predicts taken.
- R7: A not-taken update that misses changes nothing, and a later lookup of that address still misses.
- R8: The counter encoding is 00 strongly not-taken, 01 weakly not-taken, 10 weakly taken and 11 strongly taken. A hit update adds one for taken and subtracts one for not-taken, and it saturates at 11 and at 00.
- R9: A taken hit update rewrites the stored target. A not-taken hit update keeps it.
- R10: A flush invalidates all entries in one cycle. An update in the same cycle as a flush is discarded.
- R11: A lookup in the same cycle as an update to the same index returns the contents from before the update. The change is visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all entries at the next edge |
| lk_pc | input | 32 | Fetch address being looked up |
| lk_is_branch | input | 1 | Fetched instruction is a decoded direct branch |
| lk_offset | input | 32 | Signed branch offset of that instruction |
| pred_hit | output | 1 | A cache entry matched the lookup |
| pred_taken | output | 1 | Predicted direction |
| pred_target | output | 32 | Predicted target address |
| upd_valid | input | 1 | A resolved branch outcome is present |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Resolved direction |
| upd_target | input | 32 | Resolved target address |

## Verification
The lookup and the update can act on the same index in the same cycle. The update can also coincide with a flush. The bench forces both cases on purpose: it aims the lookup at the address being allocated or trained, and it asserts flush together with a taken update. Random traffic also produces these collisions, because its addresses come from a small pool of indices and tags. The judgement is based on timing: the same-cycle lookup must show the old entry, and the following cycle must show either the trained entry or, after a flush, no entry at all.

// File: rtl/bpred_pkg.sv
package bpred_pkg;
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_SNT = 2'b00;
  localparam ctr_t CTR_WNT = 2'b01;
  localparam ctr_t CTR_WT  = 2'b10;
  localparam ctr_t CTR_ST  = 2'b11;

  // Move the saturating history counter one step toward the outcome.
  function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
    ctr_t nxt;
    case (cur)
      CTR_SNT: nxt = taken ? CTR_WNT : CTR_SNT;
      CTR_WNT: nxt = taken ? CTR_WT  : CTR_SNT;
      CTR_WT:  nxt = taken ? CTR_ST  : CTR_WNT;
      default: nxt = taken ? CTR_ST  : CTR_WT;
    endcase
    return nxt;
  endfunction

  // Static fallback: a negative offset (backward branch) predicts taken.
  function automatic logic static_dir(input logic is_branch, input logic offset_sign);
    return is_branch & offset_sign;
  endfunction
endpackage

// File: rtl/bpred_table.sv
module bpred_table
  import bpred_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 7,
  parameter int TAG_W = PC_W - IDX_W - 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [TAG_W-1:0] rd_tag,
  output logic [PC_W-1:0]  rd_target,
  output ctr_t             rd_ctr,
  input  logic [IDX_W-1:0] up_idx,
  output logic             up_valid,
  output logic [TAG_W-1:0] up_tag,
  output ctr_t             up_ctr,
  input  logic             we,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             wr_tgt_en,
  input  logic [PC_W-1:0]  wr_target,
  input  ctr_t             wr_ctr
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [PC_W-1:0]    tgt_q [ENTRIES];
  ctr_t               ctr_q [ENTRIES];

  // Named event: a write that actually lands (flush discards it).
  logic commit;
  assign commit = we & ~flush;

  assign rd_valid  = valid_q[rd_idx];
  assign rd_tag    = tag_q[rd_idx];
  assign rd_target = tgt_q[rd_idx];
  assign rd_ctr    = ctr_q[rd_idx];
  assign up_valid  = valid_q[up_idx];
  assign up_tag    = tag_q[up_idx];
  assign up_ctr    = ctr_q[up_idx];

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      valid_q <= '0;
    end else if (commit) begin
      valid_q[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (commit) begin
      tag_q[wr_idx] <= wr_tag;
      ctr_q[wr_idx] <= wr_ctr;
      if (wr_tgt_en) tgt_q[wr_idx] <= wr_target;
    end
  end

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_q == '0)); // R10
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (valid_q[$past(wr_idx)] && ctr_q[$past(wr_idx)] == $past(wr_ctr))); // R6
  AST_IDLE_KEEPS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (!we && !flush) |=> $stable(valid_q)); // R7
endmodule

// File: rtl/bpred_update.sv
module bpred_update
  import bpred_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 7,
  parameter int TAG_W = PC_W - IDX_W - 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_valid,
  input  logic [PC_W-1:0]  upd_pc,
  input  logic             upd_taken,
  input  logic [PC_W-1:0]  upd_target,
  output logic [IDX_W-1:0] up_idx,
  input  logic             up_valid,
  input  logic [TAG_W-1:0] up_tag,
  input  ctr_t             up_ctr,
  output logic             we,
  output logic [IDX_W-1:0] wr_idx,
  output logic [TAG_W-1:0] wr_tag,
  output logic             wr_tgt_en,
  output logic [PC_W-1:0]  wr_target,
  output ctr_t             wr_ctr
);
  logic [TAG_W-1:0] upd_tag;
  logic upd_hit, upd_alloc;
  logic unused_upd_lsb;

  assign up_idx  = upd_pc[IDX_W+1:2];
  assign upd_tag = upd_pc[PC_W-1:IDX_W+2];
  assign unused_upd_lsb = ^upd_pc[1:0];

  // Named events for the assertions.
  assign upd_hit   = upd_valid & up_valid & (up_tag == upd_tag);
  assign upd_alloc = upd_valid & ~upd_hit & upd_taken;

  assign we        = upd_hit | upd_alloc;
  assign wr_idx    = up_idx;
  assign wr_tag    = upd_tag;
  assign wr_tgt_en = upd_taken;
  assign wr_target = upd_target;
  assign wr_ctr    = upd_hit ? ctr_step(up_ctr, upd_taken) : CTR_WT;

  AST_NO_ALLOC_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_hit && !upd_taken) |-> !we); // R7
  AST_CTR_TOP_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_hit && upd_taken && up_ctr == CTR_ST) |-> (wr_ctr == CTR_ST)); // R8
  AST_CTR_BOTTOM_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_hit && !upd_taken && up_ctr == CTR_SNT) |-> (wr_ctr == CTR_SNT)); // R8
  AST_NT_KEEPS_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_taken) |-> !wr_tgt_en); // R9
endmodule

// File: rtl/bpred_lookup.sv
module bpred_lookup
  import bpred_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 7,
  parameter int TAG_W = PC_W - IDX_W - 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PC_W-1:0]  lk_pc,
  input  logic             lk_is_branch,
  input  logic [PC_W-1:0]  lk_offset,
  output logic [IDX_W-1:0] rd_idx,
  input  logic             rd_valid,
  input  logic [TAG_W-1:0] rd_tag,
  input  logic [PC_W-1:0]  rd_target,
  input  ctr_t             rd_ctr,
  output logic             pred_hit,
  output logic             pred_taken,
  output logic [PC_W-1:0]  pred_target
);
  logic static_taken;
  logic [PC_W-1:0] static_target;
  logic unused_lk_lsb;

  assign rd_idx        = lk_pc[IDX_W+1:2];
  assign unused_lk_lsb = ^lk_pc[1:0];

  assign pred_hit      = rd_valid & (rd_tag == lk_pc[PC_W-1:IDX_W+2]);
  assign static_taken  = static_dir(lk_is_branch, lk_offset[PC_W-1]);
  assign static_target = lk_pc + lk_offset;

  assign pred_taken  = pred_hit ? rd_ctr[1] : static_taken;
  assign pred_target = pred_hit ? rd_target : static_target;

  AST_NONBRANCH_MISS_NT: assert property (@(posedge clk) disable iff (!rst_n)
    (!pred_hit && !lk_is_branch) |-> !pred_taken); // R5
  AST_FORWARD_MISS_NT: assert property (@(posedge clk) disable iff (!rst_n)
    (!pred_hit && !lk_offset[PC_W-1]) |-> !pred_taken); // R4
endmodule

// File: rtl/bpred_top.sv
module bpred_top
  import bpred_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic [PC_W-1:0] lk_pc,
  input  logic            lk_is_branch,
  input  logic [PC_W-1:0] lk_offset,
  output logic            pred_hit,
  output logic            pred_taken,
  output logic [PC_W-1:0] pred_target,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  input  logic [PC_W-1:0] upd_target
);
  localparam int TAG_W = PC_W - IDX_W - 2;

  logic [IDX_W-1:0] rd_idx, up_idx, wr_idx;
  logic             rd_valid, up_valid, we, wr_tgt_en;
  logic [TAG_W-1:0] rd_tag, up_tag, wr_tag;
  logic [PC_W-1:0]  rd_target, wr_target;
  ctr_t             rd_ctr, up_ctr, wr_ctr;

  bpred_lookup #(.PC_W(PC_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_lookup (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_is_branch(lk_is_branch),
    .lk_offset(lk_offset), .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_tag(rd_tag),
    .rd_target(rd_target), .rd_ctr(rd_ctr), .pred_hit(pred_hit),
    .pred_taken(pred_taken), .pred_target(pred_target)
  );

  bpred_update #(.PC_W(PC_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_update (
    .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_pc(upd_pc),
    .upd_taken(upd_taken), .upd_target(upd_target), .up_idx(up_idx),
    .up_valid(up_valid), .up_tag(up_tag), .up_ctr(up_ctr), .we(we),
    .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_tgt_en(wr_tgt_en),
    .wr_target(wr_target), .wr_ctr(wr_ctr)
  );

  bpred_table #(.PC_W(PC_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_table (
    .clk(clk), .rst_n(rst_n), .flush(flush), .rd_idx(rd_idx),
    .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_target(rd_target), .rd_ctr(rd_ctr),
    .up_idx(up_idx), .up_valid(up_valid), .up_tag(up_tag), .up_ctr(up_ctr),
    .we(we), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_tgt_en(wr_tgt_en),
    .wr_target(wr_target), .wr_ctr(wr_ctr)
  );

  AST_RESET_EMPTY: assert property (@(posedge clk)
    !rst_n |=> !pred_hit); // R1
  AST_ALLOC_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_taken && !flush && lk_pc == upd_pc) |=>
    ((lk_pc != $past(lk_pc)) || (upd_valid && upd_pc[IDX_W+1:2] == lk_pc[IDX_W+1:2]) || flush || pred_hit)); // R11
endmodule

// File: tb/sim_bpred_top.sv
module sim_bpred_top;
  logic        clk = 1'b0;
  logic        rst_n, flush, lk_is_branch, upd_valid, upd_taken;
  logic [31:0] lk_pc, lk_offset, upd_pc, upd_target, pred_target;
  logic        pred_hit, pred_taken;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  bit          m_valid [128];
  logic [22:0] m_tag   [128];
  logic [31:0] m_tgt   [128];
  int          m_ctr   [128];

  always #5 clk = ~clk;

  bpred_top u0 (
    .clk(clk), .rst_n(rst_n), .flush(flush), .lk_pc(lk_pc),
    .lk_is_branch(lk_is_branch), .lk_offset(lk_offset), .pred_hit(pred_hit),
    .pred_taken(pred_taken), .pred_target(pred_target), .upd_valid(upd_valid),
    .upd_pc(upd_pc), .upd_taken(upd_taken), .upd_target(upd_target)
  );

  function automatic int sat_move(int c, bit t);
    int n = t ? c + 1 : c - 1;
    if (n > 3) n = 3;
    if (n < 0) n = 0;
    return n;
  endfunction

  function automatic bit exp_hit(logic [31:0] pc);
    int i = int'(pc[8:2]);
    return m_valid[i] && (m_tag[i] == pc[31:9]);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Compare all outputs against the model (pre-edge state), then apply the edge.
  task automatic cycle(string req);
    bit h = exp_hit(lk_pc);
    int i = int'(lk_pc[8:2]);
    bit et;
    logic [31:0] eg;
    #1;
    if (h) begin
      et = (m_ctr[i] >= 2);
      eg = m_tgt[i];
    end else begin
      et = lk_is_branch && ($signed(lk_offset) < 0);
      eg = lk_pc + lk_offset;
    end
    chk({req, " hit"}, {31'd0, pred_hit}, {31'd0, h});
    chk({req, " dir"}, {31'd0, pred_taken}, {31'd0, et});
    chk({req, " tgt"}, pred_target, eg);
    @(posedge clk);
    if (flush) begin
      for (int k = 0; k < 128; k++) m_valid[k] = 0;
    end else if (upd_valid) begin
      int j = int'(upd_pc[8:2]);
      if (exp_hit(upd_pc)) begin
        m_ctr[j] = sat_move(m_ctr[j], upd_taken);
        if (upd_taken) m_tgt[j] = upd_target;
      end else if (upd_taken) begin
        m_valid[j] = 1; m_tag[j] = upd_pc[31:9];
        m_tgt[j] = upd_target; m_ctr[j] = 2;
      end
    end
    @(negedge clk);
  endtask

  task automatic set_lk(logic [31:0] pc, bit br, logic [31:0] off);
    lk_pc = pc; lk_is_branch = br; lk_offset = off;
  endtask

  task automatic set_up(bit v, logic [31:0] pc, bit t, logic [31:0] tg);
    upd_valid = v; upd_pc = pc; upd_taken = t; upd_target = tg;
  endtask

  function automatic logic [31:0] rpc();
    logic [31:0] r;
    r = 32'h0;
    r[10:9] = 2'($urandom_range(0, 3));
    r[4:2]  = 3'($urandom_range(0, 7));
    return r | 32'h4000_0000;
  endfunction

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd1234);
    for (int k = 0; k < 128; k++) begin m_valid[k] = 0; m_ctr[k] = 0; end
    rst_n = 0; flush = 0;
    set_lk(32'h0, 0, 32'h0); set_up(0, 32'h0, 0, 32'h0);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R1 reset state: lookups miss
    set_lk(32'h1000_0040, 1, 32'hFFFF_FFF0); cycle("R1");
    set_lk(32'h0000_01FC, 0, 32'h8); cycle("R1");

    // R4 static backward taken, forward not taken, R5 non-branch
    set_lk(32'h2000_0100, 1, 32'hFFFF_FF00); cycle("R4");
    set_lk(32'h2000_0100, 1, 32'h0000_0040); cycle("R4");
    set_lk(32'h2000_0100, 0, 32'hFFFF_FF00); cycle("R5");

    // R7 not-taken miss allocates nothing
    set_up(1, 32'h3000_0020, 0, 32'h3000_0400); cycle("R7");
    set_up(0, 32'h0, 0, 32'h0);
    set_lk(32'h3000_0020, 0, 32'h0); cycle("R7");

    // R11 same-cycle lookup+allocate: old contents, then R6 hit weakly taken
    set_lk(32'h3000_0020, 0, 32'h0);
    set_up(1, 32'h3000_0020, 1, 32'h3000_0800); cycle("R11");
    set_up(0, 32'h0, 0, 32'h0);
    cycle("R6");
    chk("R6 dir", {31'd0, pred_taken}, 32'd1);

    // R2 alias: same index, different tag misses
    set_lk(32'h3000_0220, 0, 32'h4); cycle("R2");

    // R8 saturate up, then walk down to strongly not-taken, R9 target
    set_lk(32'h3000_0020, 0, 32'h0);
    for (int k = 0; k < 4; k++) begin
      set_up(1, 32'h3000_0020, 1, 32'h3000_0900 + 32'(k * 4)); cycle("R8");
    end
    for (int k = 0; k < 5; k++) begin
      set_up(1, 32'h3000_0020, 0, 32'hDEAD_0000); cycle("R9");
    end
    set_up(1, 32'h3000_0020, 1, 32'h3000_0A00); cycle("R8");
    set_up(0, 32'h0, 0, 32'h0); cycle("R8");

    // R10 flush with a concurrent taken update: both dropped
    flush = 1; set_up(1, 32'h3000_0044, 1, 32'h3000_0C00); cycle("R10");
    flush = 0; set_up(0, 32'h0, 0, 32'h0);
    set_lk(32'h3000_0020, 0, 32'h0); cycle("R10");
    set_lk(32'h3000_0044, 0, 32'h0); cycle("R10");

    // Random mix
    for (int n = 0; n < 3000; n++) begin
      set_lk(rpc(), 1'($urandom_range(0, 1)),
             $urandom_range(0, 1) ? 32'hFFFF_FF00 | 32'($urandom_range(0, 255)) * 4
                                  : 32'($urandom_range(1, 255)) * 4);
      if ($urandom_range(0, 3) == 0) upd_pc = lk_pc;
      set_up(1'($urandom_range(0, 2) != 0), $urandom_range(0, 3) == 0 ? lk_pc : rpc(),
             1'($urandom_range(0, 1)), 32'h5000_0000 | 32'($urandom_range(0, 4095)) * 4);
      flush = ($urandom_range(0, 63) == 0);
      cycle(exp_hit(lk_pc) ? "R3" : (lk_is_branch ? "R4" : "R5"));
    end
    flush = 0;

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule